// File: doc/BRIEF.md
# SMBus Packet Error Code Unit

This block keeps the running packet error code of an SMBus message. Each START or repeated START clears the code and marks the next byte as the address byte, read/write bit included. Every byte after that is folded into the code as it passes on the bus. The byte engine that drives this unit gives it a strobe for each byte, the byte itself, and the controls that say where the code byte belongs in the message.

As transmitter, the engine watches the send indication. When the indication is high, the next byte it puts on the bus is the current code value, and that byte closes the message. As receiver, the byte that arrives in the same slot is folded in like any other byte. If the code is not zero after that, the message was corrupted, and a sticky error flag is set. Code checking can be switched on or off only while the surrounding peripheral is disabled.

Top module: `smbus_pec_unit`

## Requirements
- R1: The code uses the generator x^8+x^2+x+1 (constant 8'h07), starts from zero, and takes in the byte bits most significant first, one whole byte per strobe. `crc_o` shows the new value one clock after the strobe. The nine ASCII bytes "123456789" give 8'hF4.
- R2: The first byte strobed after a START is the address byte. It enters the code like any other byte but does not count as a data byte.
- R3: The code byte is the last byte of the message. In transmit mode, once the current code value has been strobed, `crc_o` reads zero and `pec_send_o` stays low until the next START.
- R4: `pec_send_o` is high exactly when all of these hold: code checking is on, `pec_xfer_i` is 1, `reload_i` is 0, `byte_cnt_i` is at least 1, the address byte is done, `byte_cnt_i`-1 data bytes have been strobed, and the code byte has not yet been strobed. It follows the inputs with one register stage.
- R5: While `reload_i` is 1, `pec_xfer_i` has no effect and `pec_send_o` stays low.
- R6: `pec_en_o` loads `pec_en_req_i` only on clocks where `periph_en_i` is 0. While `periph_en_i` is 1, changes on `pec_en_req_i` are ignored.
- R7: In receive mode (`rx_mode_i`=1), when the byte in the code slot leaves a non-zero code, `pec_err_o` goes to 1 and stays there through later messages until `err_clr_i` is pulsed. An error that arrives in the same cycle wins over the clear.
- R8: A START (`start_i`=1) sets `crc_o` to zero on the next clock and restarts the byte count. A byte strobe in that same cycle is ignored.
- R9: While `pec_en_o` is 0, `crc_o` stays zero, `pec_send_o` stays low and `pec_err_o` cannot be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| periph_en_i | input | 1 | Peripheral enable; code enable loads only while this is low |
| pec_en_req_i | input | 1 | Requested code-checking enable |
| rx_mode_i | input | 1 | 1 = receive (check the code byte), 0 = transmit |
| reload_i | input | 1 | Byte count will be reloaded; blocks the code slot |
| pec_xfer_i | input | 1 | Request a code byte at the end of the count |
| byte_cnt_i | input | CNT_W | Transfer byte count, code byte included |
| start_i | input | 1 | START or repeated START strobe |
| byte_vld_i | input | 1 | Byte strobe |
| byte_dat_i | input | 8 | Byte on the bus |
| err_clr_i | input | 1 | Clears the error flag |
| crc_o | output | 8 | Current code value |
| pec_send_o | output | 1 | The next byte is the code byte |
| pec_err_o | output | 1 | Sticky code mismatch flag |
| pec_en_o | output | 1 | Code checking currently enabled |

## Verification
The assertions expect the controls (`reload_i`, `pec_xfer_i`, `byte_cnt_i`, `rx_mode_i`) to be held steady while a message is in progress. Otherwise the code slot could move after the last data byte has gone by. The assertions also expect a START never to share a cycle with a byte that matters. The stimulus sets every control on a falling edge before it pulses START and leaves them alone until the message is over. START and byte strobes each get their own cycle, so every output is sampled on a falling edge one full clock after the strobe that changed it.

// File: rtl/smb_pec_pkg.sv
package smb_pec_pkg;
  localparam int BYTE_W   = 8;
  localparam int CODE_W   = 8;
  localparam logic [CODE_W-1:0] GEN_POLY = 8'h07;
  localparam int DEF_CNT_W = 8;

  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_DATA = 2'd1,
    PH_DONE = 2'd2
  } msg_phase_e;
endpackage

// File: rtl/pec_cfg_lock.sv
module pec_cfg_lock (
  input  logic clk,
  input  logic rst,
  input  logic periph_en_i,
  input  logic pec_en_req_i,
  output logic pec_en_o
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst)               en_q <= 1'b0;
    else if (!periph_en_i) en_q <= pec_en_req_i;
  end

  assign pec_en_o = en_q;

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
    $past(periph_en_i && !rst) |-> $stable(en_q)); // R6
endmodule

// File: rtl/pec_crc_core.sv
module pec_crc_core #(
  parameter int CODE_W = 8,
  parameter int DAT_W  = 8,
  parameter logic [CODE_W-1:0] POLY = 8'h07
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              start_i,
  input  logic              vld_i,
  input  logic [DAT_W-1:0]  dat_i,
  output logic [CODE_W-1:0] crc_o,
  output logic [CODE_W-1:0] crc_next_o
);
  localparam logic [CODE_W-1:0] ZERO = '0;

  logic [CODE_W-1:0] crc_q;
  logic [CODE_W-1:0] acc;
  logic              fb;

  always_comb begin
    acc = crc_q;
    fb  = 1'b0;
    for (int i = DAT_W-1; i >= 0; i--) begin
      fb  = acc[CODE_W-1] ^ dat_i[i];
      acc = {acc[CODE_W-2:0], 1'b0};
      if (fb) acc = acc ^ POLY;
    end
    crc_next_o = acc;
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i || start_i) crc_q <= ZERO;
    else if (vld_i)              crc_q <= crc_next_o;
  end

  assign crc_o = crc_q;

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(start_i && !rst) |-> (crc_q == ZERO)); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    $past(!vld_i && !start_i && en_i && !rst) |-> $stable(crc_q)); // R1
endmodule

// File: rtl/pec_slot_tracker.sv
module pec_slot_tracker
  import smb_pec_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             vld_i,
  input  logic [CNT_W-1:0] byte_cnt_i,
  input  logic             reload_i,
  input  logic             xfer_i,
  output logic             send_o,
  output logic             pec_byte_o
);
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] SAT  = '1;

  msg_phase_e       phase_q, phase_n;
  logic [CNT_W-1:0] dcnt_q, dcnt_n;
  logic             send_q, send_n;
  logic [CNT_W-1:0] last_idx;

  assign last_idx   = byte_cnt_i - ONE;
  assign pec_byte_o = en_i && !start_i && vld_i && send_q;

  always_comb begin
    phase_n = phase_q;
    dcnt_n  = dcnt_q;
    if (!en_i || start_i) begin
      phase_n = PH_ADDR;
      dcnt_n  = ZERO;
    end else if (vld_i) begin
      case (phase_q)
        PH_ADDR: phase_n = PH_DATA;
        PH_DATA: begin
          if (send_q)              phase_n = PH_DONE;
          else if (dcnt_q != SAT)  dcnt_n  = dcnt_q + ONE;
        end
        default: phase_n = PH_DONE;
      endcase
    end
    send_n = en_i && xfer_i && !reload_i && (byte_cnt_i != ZERO) &&
             (phase_n == PH_DATA) && (dcnt_n == last_idx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_ADDR;
      dcnt_q  <= ZERO;
      send_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      dcnt_q  <= dcnt_n;
      send_q  <= send_n;
    end
  end

  assign send_o = send_q;

  AST_ONE_CODE_BYTE: assert property (@(posedge clk) disable iff (rst)
    $past(pec_byte_o && !rst) |-> !send_q); // R3
  AST_NO_SEND_ON_RELOAD: assert property (@(posedge clk) disable iff (rst)
    $past(reload_i && !rst) |-> !send_q); // R5
  AST_NO_SEND_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    $past(start_i && !rst) |-> !send_q); // R2
endmodule

// File: rtl/smbus_pec_unit.sv
module smbus_pec_unit
  import smb_pec_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             periph_en_i,
  input  logic             pec_en_req_i,
  input  logic             rx_mode_i,
  input  logic             reload_i,
  input  logic             pec_xfer_i,
  input  logic [CNT_W-1:0] byte_cnt_i,
  input  logic             start_i,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_dat_i,
  input  logic             err_clr_i,
  output logic [7:0]       crc_o,
  output logic             pec_send_o,
  output logic             pec_err_o,
  output logic             pec_en_o
);
  localparam logic [CODE_W-1:0] ZERO = '0;

  logic              pec_en;
  logic [CODE_W-1:0] crc_next;
  logic              pec_byte;
  logic              err_q;

  pec_cfg_lock u_cfg (
    .clk          (clk),
    .rst          (rst),
    .periph_en_i  (periph_en_i),
    .pec_en_req_i (pec_en_req_i),
    .pec_en_o     (pec_en)
  );

  pec_crc_core #(
    .CODE_W (CODE_W),
    .DAT_W  (BYTE_W),
    .POLY   (GEN_POLY)
  ) u_crc (
    .clk        (clk),
    .rst        (rst),
    .en_i       (pec_en),
    .start_i    (start_i),
    .vld_i      (byte_vld_i),
    .dat_i      (byte_dat_i),
    .crc_o      (crc_o),
    .crc_next_o (crc_next)
  );

  pec_slot_tracker #(
    .CNT_W (CNT_W)
  ) u_slot (
    .clk        (clk),
    .rst        (rst),
    .en_i       (pec_en),
    .start_i    (start_i),
    .vld_i      (byte_vld_i),
    .byte_cnt_i (byte_cnt_i),
    .reload_i   (reload_i),
    .xfer_i     (pec_xfer_i),
    .send_o     (pec_send_o),
    .pec_byte_o (pec_byte)
  );

  always_ff @(posedge clk) begin
    if (rst)                                          err_q <= 1'b0;
    else if (pec_byte && rx_mode_i && crc_next != ZERO) err_q <= 1'b1;
    else if (err_clr_i)                               err_q <= 1'b0;
  end

  assign pec_err_o = err_q;
  assign pec_en_o  = pec_en;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(err_q && !err_clr_i && !rst) |-> err_q); // R7
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(!pec_en && !rst) |-> (crc_o == ZERO && !pec_send_o)); // R9
  AST_ERR_NEEDS_RX: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !err_q && !rx_mode_i) |-> !err_q); // R7
endmodule

// File: tb/sim_smbus_pec_unit.sv
module sim_smbus_pec_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       periph_en = 1'b0, pec_en_req = 1'b0, rx_mode = 1'b0;
  logic       reload = 1'b0, pec_xfer = 1'b0, start = 1'b0;
  logic       vld = 1'b0, err_clr = 1'b0;
  logic [7:0] byte_cnt = 8'd0, dat = 8'd0;
  logic [7:0] crc;
  logic       pec_send, pec_err, pec_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  smbus_pec_unit u0 (
    .clk(clk), .rst(rst), .periph_en_i(periph_en), .pec_en_req_i(pec_en_req),
    .rx_mode_i(rx_mode), .reload_i(reload), .pec_xfer_i(pec_xfer),
    .byte_cnt_i(byte_cnt), .start_i(start), .byte_vld_i(vld),
    .byte_dat_i(dat), .err_clr_i(err_clr), .crc_o(crc),
    .pec_send_o(pec_send), .pec_err_o(pec_err), .pec_en_o(pec_en)
  );

  // {address, data0, data1, data2, byte count}
  localparam logic [39:0] VEC [6] = '{
    {8'hA0, 8'h11, 8'h22, 8'h33, 8'd4},
    {8'hA1, 8'h00, 8'h00, 8'h00, 8'd1},
    {8'h5A, 8'hFF, 8'h00, 8'h00, 8'd2},
    {8'h16, 8'h80, 8'h01, 8'h00, 8'd3},
    {8'hB7, 8'h3C, 8'hC3, 8'h99, 8'd4},
    {8'h02, 8'h7E, 8'h00, 8'h00, 8'd2}
  };

  function automatic logic [7:0] m_crc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); vld = 1'b1; dat = b;
    @(negedge clk); vld = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] mc;
    logic [7:0] a;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(crc == 8'h00 && !pec_send && !pec_err && !pec_en, "reset", {crc, pec_send, pec_err, pec_en}, 0);

    // R6: enable loads while peripheral is off, then locks
    pec_en_req = 1'b1;
    @(negedge clk);
    chk(pec_en == 1'b1, "R6 load", pec_en, 1);
    periph_en = 1'b1; pec_en_req = 1'b0;
    repeat (2) @(negedge clk);
    chk(pec_en == 1'b1, "R6 locked", pec_en, 1);

    // R4/R3/R7 table walk
    pec_xfer = 1'b1;
    for (int e = 0; e < 6; e++) begin
      a = VEC[e][39:32];
      n = int'(VEC[e][7:0]);
      rx_mode  = e[0];
      byte_cnt = VEC[e][7:0];
      do_start();
      chk(!pec_send, "R4 low after start", pec_send, 0);
      send_byte(a);
      mc = m_crc(8'h00, a);
      for (int j = 0; j < n - 1; j++) begin
        chk(!pec_send, "R4 low before slot", pec_send, 0);
        send_byte(VEC[e][31 - 8*j -: 8]);
        mc = m_crc(mc, VEC[e][31 - 8*j -: 8]);
      end
      chk(pec_send == 1'b1, "R4 slot", pec_send, 1);
      chk(crc == mc, "R1 R2 value", crc, mc);
      send_byte(mc);
      if (!e[0]) chk(crc == 8'h00 && !pec_send, "R3 after code byte", {crc, pec_send}, 0);
      else       chk(!pec_err, "R7 good code", pec_err, 0);
      send_byte(8'h55);
      chk(!pec_send, "R3 no second slot", pec_send, 0);
    end

    // R1/R8: known check string after an aborted message
    byte_cnt = 8'd40; rx_mode = 1'b0;
    do_start(); send_byte(8'h31); send_byte(8'h32);
    do_start();
    chk(crc == 8'h00, "R8 start clears", crc, 0);
    @(negedge clk); start = 1'b1; vld = 1'b1; dat = 8'hAA;
    @(negedge clk); start = 1'b0; vld = 1'b0;
    chk(crc == 8'h00, "R8 byte with start ignored", crc, 0);
    for (int k = 0; k < 9; k++) send_byte(8'h31 + 8'(k));
    chk(crc == 8'hF4, "R1 check string", crc, 8'hF4);

    // R2: address alone
    do_start(); send_byte(8'hA5);
    chk(crc == m_crc(8'h00, 8'hA5), "R2 address", crc, m_crc(8'h00, 8'hA5));

    // R5: reload blocks the slot
    reload = 1'b1; byte_cnt = 8'd2;
    do_start(); send_byte(8'h10); send_byte(8'h20);
    chk(!pec_send, "R5 reload", pec_send, 0);
    reload = 1'b0;
    // R4: no request, no slot
    pec_xfer = 1'b0;
    do_start(); send_byte(8'h10); send_byte(8'h20);
    chk(!pec_send, "R4 no request", pec_send, 0);
    pec_xfer = 1'b1;

    // R7: wrong code, sticky, clear
    rx_mode = 1'b1;
    do_start(); send_byte(8'h10); send_byte(8'h20);
    mc = m_crc(m_crc(8'h00, 8'h10), 8'h20);
    send_byte(~mc);
    chk(pec_err == 1'b1, "R7 mismatch", pec_err, 1);
    do_start(); send_byte(8'h10);
    chk(pec_err == 1'b1, "R7 sticky", pec_err, 1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    chk(pec_err == 1'b0, "R7 clear", pec_err, 0);

    // R9: disabled unit stays quiet
    periph_en = 1'b0; pec_en_req = 1'b0;
    @(negedge clk);
    periph_en = 1'b1;
    do_start(); send_byte(8'h10); send_byte(8'h20); send_byte(8'h99);
    chk(crc == 8'h00 && !pec_send && !pec_err && !pec_en, "R9 disabled",
        {crc, pec_send, pec_err, pec_en}, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule